// File: doc/BRIEF.md
# Processor Status Word Update Logic

This block holds the 16-bit status word of a small fixed-point signal-processing core and decides, on every clock edge, which of its bits change. It keeps six condition codes (carry, overflow, zero, negative, unnormalized, extension), two sticky flags (limit and size), a two-bit interrupt mask and a loop flag.

The core drives the block with one-cycle strobes, and the flag values ride along with them:
- **Data ALU result** (`alu_done`): loads all six condition codes from `alu_flags`.
- **Test-word operation** (`tst_done`): refreshes only the negative, zero and overflow codes.
- **Accumulator-to-memory move** (`mov_acc`): may set the size flag and the limit flag.
- **Explicit write** (`wr_en`): replaces every implemented bit at once. Writing zeros is how software clears the sticky flags.

The flags themselves are computed elsewhere. This block only stores them and applies the rules below.

Top module: `dsp_status_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the register takes 0x0300 on that edge: interrupt mask bits 9 and 8 are 1 and every other bit is 0.
- R2: Bits 14 down to 10 always read 0, even right after a write that sets them.
- R3: A write replaces bits 15, 9..0 with `wr_data` on the next edge. In the same cycle it overrides every other update.
- R4: With `alu_done` high, bits 5..0 (extension, unnormalized, negative, zero, overflow, carry) load `alu_flags[5:0]`, one bit to the same position.
- R5: With `tst_done` high and `alu_done` low, only bits 3..1 load `alu_flags[3:1]`. Bits 5, 4 and 0 keep their values. When both strobes are high, `alu_done` governs.
- R6: With neither `alu_done` nor `tst_done` high, bits 5..0 keep their values. A move does not change them.
- R7: On `mov_acc`, the size flag (bit 7) becomes 1 when `acc_val[30]` differs from `acc_val[29]`. When those two bits are equal, it keeps its value.
- R8: Once the size flag is 1, it stays 1 until reset or a write.
- R9: The limit flag (bit 6) becomes 1 on `alu_done` with `alu_flags[1]` high, or on `mov_acc` with `mov_limited` high. It then stays 1 until reset or a write.
- R10: The loop flag (bit 15) and the interrupt mask (bits 9..8) change only through reset or a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| alu_done | input | 1 | A data ALU operation completed this cycle |
| tst_done | input | 1 | A test-word operation completed this cycle |
| alu_flags | input | 6 | Result flags {E,U,N,Z,V,C} for `alu_done` or `tst_done` |
| mov_acc | input | 1 | An accumulator is being stored to data memory |
| acc_val | input | 32 | Value of the accumulator being stored |
| mov_limited | input | 1 | Limiting occurred during that store |
| wr_en | input | 1 | Explicit write of the status word |
| wr_data | input | 16 | Value to write |
| stat_o | output | 16 | Current status word |

## Verification
A write can land in the same cycle as an ALU result, a test-word result or an accumulator store. The write must win, even over sticky bits that the store would otherwise set. The bench provokes this with directed cycles that raise all the strobes together with the flag inputs at their opposite values. Random stimulus then keeps producing such overlaps, and the overlap of `alu_done` with `tst_done` as well. After every edge the full word is compared with a model in the bench that applies the priority write, then ALU, then test-word on its own.

// File: rtl/dsp_stat_pkg.sv
package dsp_stat_pkg;

  localparam int STAT_W = 16;
  localparam int NCC    = 6;

  // bit positions of the status word
  localparam int B_LOOP  = 15;
  localparam int B_IM1   = 9;
  localparam int B_IM0   = 8;
  localparam int B_SIZE  = 7;
  localparam int B_LIMIT = 6;
  localparam int B_OVF   = 1;

  localparam logic [STAT_W-1:0] KEEP_MASK = 16'h83FF;
  localparam logic [STAT_W-1:0] RSV_MASK  = ~KEEP_MASK;
  localparam logic [STAT_W-1:0] RST_VAL   = 16'h0300;

  // condition codes that a test-word operation refreshes: N, Z, V
  localparam logic [NCC-1:0] TST_SEL = 6'b001110;

  // the two top magnitude bits below the sign disagree
  function automatic logic size_hit(input logic hi, input logic lo);
    return hi ^ lo;
  endfunction

endpackage

// File: rtl/stat_cc_bank.sv
module stat_cc_bank #(
  parameter int NCC = 6,
  parameter logic [NCC-1:0] TST_SEL = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [NCC-1:0] wr_cc,
  input  logic           alu_ld,
  input  logic           tst_ld,
  input  logic [NCC-1:0] res_cc,
  output logic [NCC-1:0] cc_q
);

  // one register per condition code; the test-word membership picks the variant
  for (genvar i = 0; i < NCC; i++) begin : g_cc
    if (TST_SEL[i]) begin : g_tst
      always_ff @(posedge clk) begin
        if (rst)                  cc_q[i] <= 1'b0;
        else if (wr_en)           cc_q[i] <= wr_cc[i];
        else if (alu_ld || tst_ld) cc_q[i] <= res_cc[i];
      end
    end else begin : g_alu_only
      always_ff @(posedge clk) begin
        if (rst)         cc_q[i] <= 1'b0;
        else if (wr_en)  cc_q[i] <= wr_cc[i];
        else if (alu_ld) cc_q[i] <= res_cc[i];
      end
    end
  end

endmodule

// File: rtl/stat_sticky.sv
module stat_sticky (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_size,
  input  logic wr_limit,
  input  logic size_set,
  input  logic limit_set,
  output logic size_q,
  output logic limit_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q  <= 1'b0;
      limit_q <= 1'b0;
    end else if (wr_en) begin
      size_q  <= wr_size;
      limit_q <= wr_limit;
    end else begin
      size_q  <= size_q | size_set;
      limit_q <= limit_q | limit_set;
    end
  end

endmodule

// File: rtl/stat_ctrl_bits.sv
module stat_ctrl_bits #(
  parameter int IM_W = 2,
  parameter logic [IM_W-1:0] IM_RST = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_loop,
  input  logic [IM_W-1:0] wr_imask,
  output logic            loop_q,
  output logic [IM_W-1:0] imask_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      loop_q  <= 1'b0;
      imask_q <= IM_RST;
    end else if (wr_en) begin
      loop_q  <= wr_loop;
      imask_q <= wr_imask;
    end
  end

endmodule

// File: rtl/dsp_status_reg.sv
module dsp_status_reg
  import dsp_stat_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alu_done,
  input  logic              tst_done,
  input  logic [NCC-1:0]    alu_flags,
  input  logic              mov_acc,
  input  logic [ACC_W-1:0]  acc_val,
  input  logic              mov_limited,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] stat_o
);

  localparam int SZ_HI = ACC_W - 2;
  localparam int SZ_LO = ACC_W - 3;
  localparam int IM_W  = B_IM1 - B_IM0 + 1;

  // named internal events
  logic evt_wr, evt_alu, evt_tst, evt_mov;
  logic size_evt, limit_evt;

  assign evt_wr    = wr_en;
  assign evt_alu   = alu_done;
  assign evt_tst   = tst_done & ~alu_done;
  assign evt_mov   = mov_acc;
  assign size_evt  = evt_mov & size_hit(acc_val[SZ_HI], acc_val[SZ_LO]);
  assign limit_evt = (evt_alu & alu_flags[B_OVF]) | (evt_mov & mov_limited);

  logic [NCC-1:0]  cc_q;
  logic            size_q, limit_q, loop_q;
  logic [IM_W-1:0] imask_q;

  stat_cc_bank #(.NCC(NCC), .TST_SEL(TST_SEL)) cc_i (
    .clk(clk), .rst(rst), .wr_en(evt_wr), .wr_cc(wr_data[NCC-1:0]),
    .alu_ld(evt_alu), .tst_ld(evt_tst), .res_cc(alu_flags), .cc_q(cc_q)
  );

  stat_sticky sticky_i (
    .clk(clk), .rst(rst), .wr_en(evt_wr),
    .wr_size(wr_data[B_SIZE]), .wr_limit(wr_data[B_LIMIT]),
    .size_set(size_evt), .limit_set(limit_evt),
    .size_q(size_q), .limit_q(limit_q)
  );

  stat_ctrl_bits #(.IM_W(IM_W), .IM_RST(RST_VAL[B_IM1:B_IM0])) ctrl_i (
    .clk(clk), .rst(rst), .wr_en(evt_wr),
    .wr_loop(wr_data[B_LOOP]), .wr_imask(wr_data[B_IM1:B_IM0]),
    .loop_q(loop_q), .imask_q(imask_q)
  );

  always_comb begin
    stat_o                = '0;
    stat_o[NCC-1:0]       = cc_q;
    stat_o[B_LIMIT]       = limit_q;
    stat_o[B_SIZE]        = size_q;
    stat_o[B_IM1:B_IM0]   = imask_q;
    stat_o[B_LOOP]        = loop_q;
  end

endmodule

// File: rtl/dsp_status_reg_chk.sv
module dsp_status_reg_chk
  import dsp_stat_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              alu_done,
  input logic              tst_done,
  input logic [NCC-1:0]    alu_flags,
  input logic              wr_en,
  input logic [STAT_W-1:0] wr_data,
  input logic [ACC_W-1:0]  acc_val,
  input logic              evt_mov,
  input logic              size_evt,
  input logic              limit_evt,
  input logic [STAT_W-1:0] stat_o
);

  // R1
  rst_val_chk: assert property (@(posedge clk) rst |=> stat_o == RST_VAL);

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_o & RSV_MASK) == '0);

  // R3
  wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> stat_o == ($past(wr_data) & KEEP_MASK));

  // R4
  alu_load_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_done && !wr_en) |=> stat_o[NCC-1:0] == $past(alu_flags));

  // R5
  tst_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (tst_done && !alu_done && !wr_en) |=>
      ($stable(stat_o[5:4]) && $stable(stat_o[0]) && stat_o[3:1] == $past(alu_flags[3:1])));

  // R6
  cc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!alu_done && !tst_done && !wr_en) |=> $stable(stat_o[NCC-1:0]));

  // R7
  size_set_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_mov && (acc_val[ACC_W-2] != acc_val[ACC_W-3]) && !wr_en) |=> stat_o[B_SIZE]);

  // R8
  size_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_o[B_SIZE] && !wr_en) |=> stat_o[B_SIZE]);

  // R9
  limit_set_chk: assert property (@(posedge clk) disable iff (rst)
    (limit_evt && !wr_en) |=> stat_o[B_LIMIT]);

  // R9
  limit_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_o[B_LIMIT] && !wr_en) |=> stat_o[B_LIMIT]);

  // R7
  size_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!size_evt && !wr_en && !stat_o[B_SIZE]) |=> !stat_o[B_SIZE]);

  // R10
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(stat_o[B_LOOP]) && $stable(stat_o[B_IM1:B_IM0])));

endmodule

bind dsp_status_reg dsp_status_reg_chk #(.ACC_W(ACC_W)) chk_i (
  .clk(clk), .rst(rst), .alu_done(alu_done), .tst_done(tst_done),
  .alu_flags(alu_flags), .wr_en(wr_en), .wr_data(wr_data), .acc_val(acc_val),
  .evt_mov(evt_mov), .size_evt(size_evt), .limit_evt(limit_evt), .stat_o(stat_o)
);

// File: tb/dsp_status_reg_tb_top.sv
module dsp_status_reg_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        alu_done = 1'b0, tst_done = 1'b0, mov_acc = 1'b0;
  logic        mov_limited = 1'b0, wr_en = 1'b0;
  logic [5:0]  alu_flags = '0;
  logic [31:0] acc_val = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] stat_o;

  int n_chk = 0, n_bad = 0;
  logic [15:0] model = 16'h0300;

  always #5 clk = ~clk;

  dsp_status_reg dut_i (
    .clk(clk), .rst(rst), .alu_done(alu_done), .tst_done(tst_done),
    .alu_flags(alu_flags), .mov_acc(mov_acc), .acc_val(acc_val),
    .mov_limited(mov_limited), .wr_en(wr_en), .wr_data(wr_data), .stat_o(stat_o)
  );

  // bench view of the next status word
  function automatic logic [15:0] next_word(
    input logic [15:0] cur, input logic a, input logic t, input logic m,
    input logic w, input logic [5:0] f, input logic [31:0] acc,
    input logic lim, input logic [15:0] wd);
    logic [15:0] n;
    if (w) return {wd[15], 5'b0, wd[9:0]};
    n = cur;
    if (m && (acc[30] != acc[29])) n[7] = 1'b1;
    if (m && lim) n[6] = 1'b1;
    if (a) begin
      n[5:0] = f;
      if (f[1]) n[6] = 1'b1;
    end else if (t) begin
      n[3] = f[3]; n[2] = f[2]; n[1] = f[1];
    end
    return n;
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    n_chk++;
    if (stat_o !== exp) begin
      n_bad++;
      $display("FAIL %s: stat_o=%h expected=%h", req, stat_o, exp);
    end
  endtask

  task automatic step(input logic a, input logic t, input logic [5:0] f,
                      input logic m, input logic [31:0] acc, input logic lim,
                      input logic w, input logic [15:0] wd);
    alu_done = a; tst_done = t; alu_flags = f; mov_acc = m; acc_val = acc;
    mov_limited = lim; wr_en = w; wr_data = wd;
    model = next_word(model, a, t, m, w, f, acc, lim, wd);
    @(posedge clk); #1;
    alu_done = 0; tst_done = 0; mov_acc = 0; wr_en = 0;
  endtask

  initial begin : watchdog
    #2000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    string tag;
    repeat (2) @(posedge clk);
    #1; rst = 0;
    check("R1", 16'h0300);
    step(0,0,0,0,0,0,1,16'hFFFF);       check("R2", 16'h83FF);
    step(1,1,6'h3F,1,32'h4000_0000,1,1,16'h0000); check("R3", 16'h0000);
    step(1,0,6'b101010,0,0,0,0,0);      check("R4", 16'h006A);
    step(0,1,6'b010101,0,0,0,0,0);      check("R5", 16'h0064);
    step(1,1,6'b010001,0,0,0,0,0);      check("R5", 16'h0051);
    step(0,0,6'h3F,1,32'h6000_0000,0,0,0); check("R6", 16'h0051);
    step(0,0,0,1,32'h9FFF_FFFF,0,0,0);  check("R7", 16'h0051);
    step(0,0,0,1,32'h4000_0000,0,0,0);  check("R7", 16'h00D1);
    step(0,0,0,1,32'h0000_0000,0,0,0);  check("R8", 16'h00D1);
    step(1,0,6'b000000,0,0,0,0,0);      check("R9", 16'h00C0);
    step(0,0,0,0,0,0,1,16'h8100);       check("R3", 16'h8100);
    step(0,0,0,1,32'h0,1,0,0);          check("R9", 16'h8140);
    step(1,1,6'h3F,1,32'h2000_0000,1,0,0); check("R10", 16'h81FF);
    rst = 1; @(posedge clk); #1; rst = 0; model = 16'h0300;
    check("R1", 16'h0300);
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic a, t, m, w;
      a = ($urandom % 3) == 0;
      t = ($urandom % 3) == 0;
      m = ($urandom % 3) == 0;
      w = ($urandom % 10) == 0;
      tag = w ? "R3" : a ? "R4" : t ? "R5" : m ? "R7" : "R6";
      step(a, t, 6'($urandom), m, $urandom, 1'(($urandom % 4) == 0), w, 16'($urandom));
      check(tag, model);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule